// File: doc/BRIEF.md
# Three-Operand Logic and Shift Unit

This unit is the combinational datapath slice for the bitwise and shift members of the three-register integer instruction group (primary opcode 0x05). It takes a 32-bit instruction word and two register operand values, b and c. It returns the value that the instruction writes to its destination register a. It also returns the three register indices that the instruction names. Operands and the result are `W` bits wide, and `W` is a power of two.

The instruction word is split into bytes:

- bits 31..24 hold the primary opcode.
- bits 23..16 hold the sub-group: 0x02 for bitwise logic, 0x03 for shifts and rotates.
- bits 15..12 hold the function nibble.
- bits 11..8 hold the destination index.
- bits 7..4 hold the b index.
- bits 3..0 hold the c index.

The logic sub-group covers ten two-input functions. Six are the usual gates. The other four are the implication and nonimplication functions. The shift sub-group supports left and right shifts with three kinds of fill for the vacated bits:

- zeros,
- ones,
- the sign bit, on arithmetic right shifts.

It also supports rotates in both directions. Any word outside these encodings raises `illegal` and forces the result to zero. The surrounding pipeline can then trap on it.

Top module: `lsu3_unit`

## Requirements
- R1: With opcode 0x05 and sub-group 0x02, nibbles 0 to 5 give b AND c, b OR c, b XOR c, NOT(b AND c), NOT(b OR c) and NOT(b XOR c), bit by bit.
- R2: In the logic sub-group, nibble 6 gives (NOT b) AND c, and nibble 7 gives b AND (NOT c).
- R3: In the logic sub-group, nibble 8 gives (NOT b) OR c, and nibble 9 gives b OR (NOT c).
- R4: With sub-group 0x03, nibble 2 shifts b left and nibble 3 shifts b right, and both fill the vacated bits with zeros.
- R5: In the shift sub-group, nibble 4 shifts left and nibble 5 shifts right, and both fill the vacated bits with ones.
- R6: In the shift sub-group, nibble 0 is an arithmetic left shift that fills with zeros. Nibble 1 is an arithmetic right shift that fills with copies of b's top bit.
- R7: In the shift sub-group, nibble 6 rotates b left and nibble 7 rotates b right, with no bits lost.
- R8: The shift or rotate amount is c modulo W, so only the low log2(W) bits of c count. An amount of zero returns b unchanged for every shift and rotate.
- R9: `dst_idx`, `b_idx` and `c_idx` always equal instruction bits 11..8, 7..4 and 3..0.
- R10: `illegal` is 1 and `result` is all zeros in any of these cases: the opcode is not 0x05, the sub-group is neither 0x02 nor 0x03, the logic nibble is 0xA to 0xF, or the shift nibble is 8 to 0xF. Otherwise `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word being executed |
| opnd_b | input | W | Value of source register b |
| opnd_c | input | W | Value of source register c (shift amount in its low bits) |
| result | output | W | Value to write to register a |
| illegal | output | 1 | Encoding is not a logic or shift function of this unit |
| dst_idx | output | 4 | Destination register index |
| b_idx | output | 4 | Source b register index |
| c_idx | output | 4 | Source c register index |

## Verification
The unit holds no state, so any decode or datapath error shows on `result` or `illegal` in the same evaluation as the instruction that exposes it. There is no latency to wait out. A wrong function-to-nibble mapping gives a wrong bit pattern for exactly the nibbles that were swapped. A mis-sized amount field shows only when c has bits set above log2(W), or when the amount is zero or W-1.

Fill errors are easiest to see with particular operands:

- A wrong sign fill shows only for right shifts of operands whose top bit is set.
- A wrong one fill shows only for nonzero amounts.

The bench therefore pairs random operands with directed amounts and signs at these edges.

// File: rtl/lsu3_pkg.sv
package lsu3_pkg;

  localparam logic [7:0] OPC_3REG   = 8'h05;
  localparam logic [7:0] SUB_LOGIC  = 8'h02;
  localparam logic [7:0] SUB_SHIFT  = 8'h03;
  localparam logic [3:0] LOGIC_LAST = 4'h9;

  typedef enum logic [3:0] {
    LF_AND   = 4'h0,
    LF_OR    = 4'h1,
    LF_XOR   = 4'h2,
    LF_NAND  = 4'h3,
    LF_NOR   = 4'h4,
    LF_XNOR  = 4'h5,
    LF_CNIMP = 4'h6,
    LF_MNIMP = 4'h7,
    LF_MIMP  = 4'h8,
    LF_CIMP  = 4'h9
  } logic_fn_e;

  typedef enum logic [2:0] {
    SH_AL  = 3'd0,
    SH_AR  = 3'd1,
    SH_ZL  = 3'd2,
    SH_ZR  = 3'd3,
    SH_OL  = 3'd4,
    SH_OR  = 3'd5,
    SH_ROL = 3'd6,
    SH_ROR = 3'd7
  } shift_fn_e;

  typedef struct packed {
    logic       is_logic;
    logic       is_shift;
    logic       bad;
    logic [3:0] fn;
    logic [3:0] dst;
    logic [3:0] srcb;
    logic [3:0] srcc;
  } dec_t;

endpackage

// File: rtl/lsu3_decode.sv
module lsu3_decode
  import lsu3_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic       opc_ok;
  logic [7:0] sub;
  logic [3:0] nib;

  always_comb begin
    opc_ok       = (instr[31:24] == OPC_3REG);
    sub          = instr[23:16];
    nib          = instr[15:12];
    dec.is_logic = opc_ok && (sub == SUB_LOGIC) && (nib <= LOGIC_LAST);
    dec.is_shift = opc_ok && (sub == SUB_SHIFT) && !nib[3];
    dec.bad      = !(dec.is_logic || dec.is_shift);
    dec.fn       = nib;
    dec.dst      = instr[11:8];
    dec.srcb     = instr[7:4];
    dec.srcc     = instr[3:0];
    // R10
    one_class_chk: assert ($countones({dec.is_logic, dec.is_shift, dec.bad}) == 1)
      else $error("decode class not unique");
  end

endmodule

// File: rtl/lsu3_logic.sv
module lsu3_logic
  import lsu3_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] res
);

  always_comb begin
    case (fn)
      LF_AND:   res = b & c;
      LF_OR:    res = b | c;
      LF_XOR:   res = b ^ c;
      LF_NAND:  res = ~(b & c);
      LF_NOR:   res = ~(b | c);
      LF_XNOR:  res = ~(b ^ c);
      LF_CNIMP: res = ~b & c;
      LF_MNIMP: res = b & ~c;
      LF_MIMP:  res = ~b | c;
      LF_CIMP:  res = b | ~c;
      default:  res = '0;
    endcase
    // R1
    xor_recover_chk: assert (fn != LF_XOR || ((res ^ b) == c))
      else $error("xor result does not recover c");
    // R3
    mimp_cover_chk: assert (fn != LF_MIMP || ((res | (b & ~c)) == {W{1'b1}}))
      else $error("implication result leaves a gap");
  end

endmodule

// File: rtl/lsu3_shift.sv
module lsu3_shift
  import lsu3_pkg::*;
#(
  parameter int W  = 64,
  parameter int AW = $clog2(W)
) (
  input  logic [2:0]    fn,
  input  logic [W-1:0]  b,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  res
);

  logic [W-1:0]   ones;
  logic [2*W-1:0] dbl_l;
  logic [2*W-1:0] dbl_r;

  always_comb begin
    ones  = '1;
    dbl_l = {b, b} << amt;
    dbl_r = {b, b} >> amt;
    case (fn)
      SH_AL, SH_ZL: res = b << amt;
      SH_AR:        res = $signed(b) >>> amt;
      SH_ZR:        res = b >> amt;
      SH_OL:        res = (b << amt) | ~(ones << amt);
      SH_OR:        res = (b >> amt) | ~(ones >> amt);
      SH_ROL:       res = dbl_l[2*W-1:W];
      SH_ROR:       res = dbl_r[W-1:0];
      default:      res = b;
    endcase
    // R8
    zero_amt_chk: assert (amt != '0 || res == b)
      else $error("zero amount altered operand");
    // R7
    rot_pop_chk: assert (!(fn == SH_ROL || fn == SH_ROR) || $countones(res) == $countones(b))
      else $error("rotate lost bits");
    // R4
    zfill_pop_chk: assert (!(fn == SH_ZL || fn == SH_ZR || fn == SH_AL) || $countones(res) <= $countones(b))
      else $error("zero fill added ones");
    // R5
    ofill_pop_chk: assert (!(fn == SH_OL || fn == SH_OR) || $countones(res) >= $countones(b))
      else $error("one fill removed ones");
  end

endmodule

// File: rtl/lsu3_unit.sv
module lsu3_unit
  import lsu3_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [31:0]  instr,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] opnd_c,
  output logic [W-1:0] result,
  output logic         illegal,
  output logic [3:0]   dst_idx,
  output logic [3:0]   b_idx,
  output logic [3:0]   c_idx
);

  localparam int AW = $clog2(W);

  dec_t         dec;
  logic [W-1:0] logic_res;
  logic [W-1:0] shift_res;

  lsu3_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  lsu3_logic #(.W(W)) u_logic (
    .fn  (dec.fn),
    .b   (opnd_b),
    .c   (opnd_c),
    .res (logic_res)
  );

  lsu3_shift #(.W(W), .AW(AW)) u_shift (
    .fn  (dec.fn[2:0]),
    .b   (opnd_b),
    .amt (opnd_c[AW-1:0]),
    .res (shift_res)
  );

  always_comb begin
    if (dec.is_logic)      result = logic_res;
    else if (dec.is_shift) result = shift_res;
    else                   result = '0;
    illegal = dec.bad;
    dst_idx = dec.dst;
    b_idx   = dec.srcb;
    c_idx   = dec.srcc;
  end

endmodule

// File: tb/tb_lsu3_unit.sv
module tb_lsu3_unit;

  localparam int W = 64;

  logic         clk;
  logic [31:0]  instr;
  logic [W-1:0] opnd_b, opnd_c, result;
  logic         illegal;
  logic [3:0]   dst_idx, b_idx, c_idx;
  int           checks, errors;
  bit           done;

  lsu3_unit #(.W(W)) dut (
    .instr(instr), .opnd_b(opnd_b), .opnd_c(opnd_c), .result(result),
    .illegal(illegal), .dst_idx(dst_idx), .b_idx(b_idx), .c_idx(c_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference model: returns {illegal, result}
  function automatic logic [W:0] model(logic [31:0] ins, logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] r;
    logic [3:0]   tt;
    logic [3:0]   nib;
    logic         fill;
    int           amt;
    r   = '0;
    nib = ins[15:12];
    amt = int'(c % W);
    if (ins[31:24] != 8'h05) return {1'b1, {W{1'b0}}};
    if (ins[23:16] == 8'h02 && nib <= 4'h9) begin
      case (nib)
        4'h0: tt = 4'b1000; 4'h1: tt = 4'b1110; 4'h2: tt = 4'b0110;
        4'h3: tt = 4'b0111; 4'h4: tt = 4'b0001; 4'h5: tt = 4'b1001;
        4'h6: tt = 4'b0010; 4'h7: tt = 4'b0100; 4'h8: tt = 4'b1011;
        default: tt = 4'b1101;
      endcase
      for (int i = 0; i < W; i++) r[i] = tt[{b[i], c[i]}];
      return {1'b0, r};
    end
    if (ins[23:16] == 8'h03 && nib <= 4'h7) begin
      fill = (nib == 4'h4 || nib == 4'h5) ? 1'b1 : (nib == 4'h1) ? b[W-1] : 1'b0;
      for (int i = 0; i < W; i++) begin
        if (nib == 4'h6)      r[i] = b[(i - amt + W) % W];
        else if (nib == 4'h7) r[i] = b[(i + amt) % W];
        else if (nib[0] == 1'b0) r[i] = (i - amt >= 0) ? b[i - amt] : fill;
        else                  r[i] = (i + amt < W) ? b[i + amt] : fill;
      end
      return {1'b0, r};
    end
    return {1'b1, {W{1'b0}}};
  endfunction

  function automatic logic [31:0] mk(logic [7:0] sub, logic [3:0] nib);
    return {8'h05, sub, nib, 4'h3, 4'hA, 4'h5};
  endfunction

  task automatic run(string tag, logic [31:0] ins, logic [W-1:0] b, logic [W-1:0] c);
    logic [W:0] exp;
    @(posedge clk);
    #1;
    instr = ins; opnd_b = b; opnd_c = c;
    @(negedge clk);
    exp = model(ins, b, c);
    checks++;
    if (result !== exp[W-1:0] || illegal !== exp[W]) begin
      errors++;
      $display("FAIL %s instr=%h actual=%b/%h expected=%b/%h", tag, ins,
               illegal, result, exp[W], exp[W-1:0]);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pb, pc, nb;
    logic [31:0]  ri;
    checks = 0; errors = 0; done = 0;
    void'($urandom(32'd4242));
    instr = 32'h0; opnd_b = '0; opnd_c = '0;
    // R10 idle word (all zero) is foreign
    @(negedge clk);
    checks++;
    if (illegal !== 1'b1 || result !== '0) begin
      errors++;
      $display("FAIL R10 idle actual=%b/%h expected=1/0", illegal, result);
    end
    pb = 64'hF0F0_F0F0_F0F0_F0F0;
    pc = 64'hFF00_FF00_FF00_FF00;
    nb = 64'h8123_4567_89AB_CDEF;
    for (int n = 0; n < 6; n++) run("R1", mk(8'h02, 4'(n)), pb, pc);
    run("R2", mk(8'h02, 4'h6), pb, pc);
    run("R2", mk(8'h02, 4'h7), pb, pc);
    run("R3", mk(8'h02, 4'h8), pb, pc);
    run("R3", mk(8'h02, 4'h9), pb, pc);
    run("R10", mk(8'h02, 4'hA), pb, pc);
    run("R10", mk(8'h02, 4'hF), pb, pc);
    run("R10", mk(8'h03, 4'h8), pb, pc);
    run("R10", mk(8'h04, 4'h0), pb, pc);
    run("R10", {8'h06, 8'h02, 16'h0123}, pb, pc);
    run("R4", mk(8'h03, 4'h2), nb, 64'd12);
    run("R4", mk(8'h03, 4'h3), nb, 64'd63);
    run("R5", mk(8'h03, 4'h4), nb, 64'd7);
    run("R5", mk(8'h03, 4'h5), nb, 64'd63);
    run("R6", mk(8'h03, 4'h1), nb, 64'd9);
    run("R6", mk(8'h03, 4'h1), ~nb, 64'd9);
    run("R6", mk(8'h03, 4'h0), nb, 64'd5);
    run("R7", mk(8'h03, 4'h6), nb, 64'd63);
    run("R7", mk(8'h03, 4'h7), nb, 64'd1);
    for (int n = 0; n < 8; n++) run("R8", mk(8'h03, 4'(n)), nb, 64'd0);
    run("R8", mk(8'h03, 4'h3), nb, 64'hFFFF_0000_0000_0043);
    run("R8", mk(8'h03, 4'h6), nb, 64'd64);
    // R9 field decode
    run("R9", 32'h0502_4C7E, pb, pc);
    checks++;
    if (dst_idx !== 4'hC || b_idx !== 4'h7 || c_idx !== 4'hE) begin
      errors++;
      $display("FAIL R9 actual=%h%h%h expected=c7e", dst_idx, b_idx, c_idx);
    end
    for (int k = 0; k < 400; k++) begin
      ri = {8'h05, (($urandom % 4) == 0) ? 8'($urandom) : 8'(8'h02 + ($urandom % 2)),
            4'($urandom), 12'($urandom)};
      if (($urandom % 16) == 0) ri[31:24] = 8'($urandom);
      pb = {$urandom, $urandom};
      pc = (($urandom % 3) == 0) ? {$urandom, $urandom} : 64'($urandom % 70);
      run(ri[23:16] == 8'h02 ? "R1" : ri[23:16] == 8'h03 ? "R8" : "R10", ri, pb, pc);
      checks++;
      if (dst_idx !== ri[11:8] || b_idx !== ri[7:4] || c_idx !== ri[3:0]) begin
        errors++;
        $display("FAIL R9 actual=%h%h%h expected=%h", dst_idx, b_idx, c_idx, ri[11:0]);
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule